// File: doc/BRIEF.md
# Pipelined Multiply-Add Array

This block is an unsigned k-by-k array multiplier extended to a fused multiply-add: it returns a*x + y as a 2k-bit result. The three operands a, x and y are each k bits wide. The multiples of a are formed by AND gates, one multiple for each bit of x. A one-sided chain of carry-save rows reduces them, and a single carry-propagate adder at the bottom turns the redundant sum/carry pair into plain binary.

The addend costs no extra row. A plain multiplier array starts with a carry-save row whose third input is tied to zero. Here that input carries y, so the first row already holds y plus the first two multiples. The chain therefore has k-1 carry-save rows. With the PIPE parameter at 1, a register follows each row and another follows the final adder, so a new operand set can be accepted on every clock. The latency is k cycles. A valid bit travels with each operand set, and the operands that later rows still need travel down beside the partial sums. With PIPE at 0 the whole array is combinational.

Top module: `mac_array`

## Requirements
- R1: For every unsigned a, x and y of K bits, the result carried with an asserted valid_out equals a*x + y exactly, as a 2K-bit value.
- R2: Each carry-save row keeps the arithmetic value: its sum vector plus its carry vector equals the sum of its three input vectors, and bit 0 of every carry vector is 0.
- R3: The addend enters the first carry-save row. With y = 0 the result is the plain product a*x, and with a = 0 or x = 0 the result is y.
- R4: With PIPE = 1, an operand set presented with valid_in high on one rising edge appears on result, with valid_out high, exactly K rising edges later (K-1 carry-save row registers plus one adder register). Operand sets may be presented on consecutive edges with no gap.
- R5: valid_out is valid_in delayed by the latency. Cycles with valid_in low produce cycles with valid_out low, in the same order and with the same spacing.
- R6: The result never overflows. The largest inputs (all ones) give 2^(2K) - 2^K, and no carry leaves the top bit of any carry-save row or of the final adder.
- R7: rst_n low clears every valid bit in the pipeline. valid_in high while reset is held is ignored, and valid_out stays low after release until a fresh valid operand set has passed through.
- R8: With PIPE = 0 the block is combinational: result equals a*x + y and valid_out equals valid_in in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the pipeline registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| valid_in | input | 1 | Marks a_in, x_in and y_in as an operand set to process |
| a_in | input | K | Multiplicand, unsigned |
| x_in | input | K | Multiplier, unsigned; each bit selects one multiple of a_in |
| y_in | input | K | Addend, unsigned, fed into the first carry-save row |
| valid_out | output | 1 | Marks result as holding a completed a*x + y |
| result | output | 2K | Unsigned a*x + y |

## Verification
Assertions inside each row check on every clocked cycle that the row keeps the value of its inputs and spills no carry off the top. They also check that each valid register copies its input on the next edge. At the adder, an assertion checks that no carry leaves the top bit. The end-to-end arithmetic, the exact K-cycle latency, the spacing of bubbles and the reset behaviour can only be shown by the bench's scenarios. These include corner operands, back-to-back and gapped streams for K = 4 and K = 8, and an exhaustive sweep of the combinational variant.

// File: rtl/mac_array_pkg.sv
package mac_array_pkg;

  // Cycles from an accepted operand set to its result.
  function automatic int unsigned mac_latency(input int unsigned k, input bit pipe);
    return pipe ? k : 0;
  endfunction

  // Majority of three bits: the carry of a full adder.
  function automatic logic fa_carry(input logic p, input logic q, input logic r);
    return (p & q) | (p & r) | (q & r);
  endfunction

  // Sum bit of a full adder.
  function automatic logic fa_sum(input logic p, input logic q, input logic r);
    return p ^ q ^ r;
  endfunction

endpackage

// File: rtl/mac_rst_sync.sv
module mac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/mac_pp_gen.sv
module mac_pp_gen #(
  parameter int unsigned K  = 8,
  parameter int unsigned W  = 2 * K,
  parameter int unsigned SH = 0
) (
  input  logic [K-1:0] mult_a,
  input  logic         sel_bit,
  output logic [W-1:0] pp
);

  // One AND gate for each bit of the multiple, placed at weight SH.
  for (genvar j = 0; j < W; j++) begin : g_bit
    if (j >= SH && j < SH + K) begin : g_and
      assign pp[j] = mult_a[j-SH] & sel_bit;
    end else begin : g_zero
      assign pp[j] = 1'b0;
    end
  end

endmodule

// File: rtl/mac_csa_row.sv
module mac_csa_row #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] in_p,
  input  logic [W-1:0] in_q,
  input  logic [W-1:0] in_r,
  output logic [W-1:0] sum_v,
  output logic [W-1:0] carry_v,
  output logic         spill
);

  import mac_array_pkg::*;

  logic [W:0] cy;

  assign cy[0] = 1'b0;
  for (genvar j = 0; j < W; j++) begin : g_fa
    assign sum_v[j] = fa_sum(in_p[j], in_q[j], in_r[j]);
    assign cy[j+1]  = fa_carry(in_p[j], in_q[j], in_r[j]);
  end

  // Carries move one column left: only neighbouring columns are wired.
  assign carry_v = cy[W-1:0];
  assign spill   = cy[W];

endmodule

// File: rtl/mac_cpa.sv
module mac_cpa #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] op_s,
  input  logic [W-1:0] op_c,
  output logic [W-1:0] total,
  output logic         cout
);

  import mac_array_pkg::*;

  logic [W:0] rc;

  assign rc[0] = 1'b0;
  for (genvar j = 0; j < W; j++) begin : g_ripple
    assign total[j] = fa_sum(op_s[j], op_c[j], rc[j]);
    assign rc[j+1]  = fa_carry(op_s[j], op_c[j], rc[j]);
  end

  assign cout = rc[W];

endmodule

// File: rtl/mac_stage.sv
module mac_stage #(
  parameter int unsigned K    = 8,
  parameter int unsigned W    = 2 * K,
  parameter int unsigned IDX  = 1,
  parameter bit          PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_in,
  input  logic [K-1:0] a_in,
  input  logic [K-1:0] x_in,
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] c_in,
  output logic         v_out,
  output logic [K-1:0] a_out,
  output logic [K-1:0] x_out,
  output logic [W-1:0] s_out,
  output logic [W-1:0] c_out
);

  logic [W-1:0] pp;
  logic [W-1:0] s_nxt;
  logic [W-1:0] c_nxt;
  logic         spill;

  mac_pp_gen #(.K(K), .W(W), .SH(IDX)) u_pp (
    .mult_a  (a_in),
    .sel_bit (x_in[IDX]),
    .pp      (pp)
  );

  mac_csa_row #(.W(W)) u_row (
    .in_p    (s_in),
    .in_q    (c_in),
    .in_r    (pp),
    .sum_v   (s_nxt),
    .carry_v (c_nxt),
    .spill   (spill)
  );

  AST_CSA_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    v_in |-> (s_nxt + c_nxt == s_in + c_in + pp) && !c_nxt[0]); // R2
  AST_ROW_NO_SPILL: assert property (@(posedge clk) disable iff (!rst_n)
    v_in |-> !spill); // R6

  if (PIPE) begin : g_reg
    logic         v_q;
    logic [K-1:0] a_q, a_d;
    logic [K-1:0] x_q, x_d;
    logic [W-1:0] s_q, s_d;
    logic [W-1:0] c_q, c_d;

    // Next state: data registers load only when a valid set passes.
    always_comb begin
      a_d = a_q;
      x_d = x_q;
      s_d = s_q;
      c_d = c_q;
      if (v_in) begin
        a_d = a_in;
        x_d = x_in;
        s_d = s_nxt;
        c_d = c_nxt;
      end
    end

    always_ff @(posedge clk) begin
      a_q <= a_d;
      x_q <= x_d;
      s_q <= s_d;
      c_q <= c_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_in;
    end

    AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
      v_in |=> v_q); // R5
    AST_VALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !v_in |=> !v_q); // R5

    assign v_out = v_q;
    assign a_out = a_q;
    assign x_out = x_q;
    assign s_out = s_q;
    assign c_out = c_q;
  end else begin : g_wire
    assign v_out = v_in;
    assign a_out = a_in;
    assign x_out = x_in;
    assign s_out = s_nxt;
    assign c_out = c_nxt;
  end

endmodule

// File: rtl/mac_array.sv
module mac_array #(
  parameter int unsigned K    = 8,
  parameter bit          PIPE = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid_in,
  input  logic [K-1:0]   a_in,
  input  logic [K-1:0]   x_in,
  input  logic [K-1:0]   y_in,
  output logic           valid_out,
  output logic [2*K-1:0] result
);

  import mac_array_pkg::*;

  localparam int unsigned W    = 2 * K;
  localparam int unsigned ROWS = K - 1;
  localparam int unsigned LAT  = mac_latency(K, PIPE);

  logic rst_i_n;

  mac_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Chain index r feeds carry-save row r; index ROWS is the adder input.
  logic         v_ch [ROWS+1];
  logic [K-1:0] a_ch [ROWS+1];
  logic [K-1:0] x_ch [ROWS+1];
  logic [W-1:0] s_ch [ROWS+1];
  logic [W-1:0] c_ch [ROWS+1];
  logic [W-1:0] pp0;

  mac_pp_gen #(.K(K), .W(W), .SH(0)) u_pp0 (
    .mult_a  (a_in),
    .sel_bit (x_in[0]),
    .pp      (pp0)
  );

  // The addend takes the slot a plain multiplier would tie to zero.
  assign v_ch[0] = valid_in;
  assign a_ch[0] = a_in;
  assign x_ch[0] = x_in;
  assign s_ch[0] = {{K{1'b0}}, y_in};
  assign c_ch[0] = pp0;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    mac_stage #(.K(K), .W(W), .IDX(r + 1), .PIPE(PIPE)) u_stage (
      .clk   (clk),
      .rst_n (rst_i_n),
      .v_in  (v_ch[r]),
      .a_in  (a_ch[r]),
      .x_in  (x_ch[r]),
      .s_in  (s_ch[r]),
      .c_in  (c_ch[r]),
      .v_out (v_ch[r+1]),
      .a_out (a_ch[r+1]),
      .x_out (x_ch[r+1]),
      .s_out (s_ch[r+1]),
      .c_out (c_ch[r+1])
    );
  end

  logic [W-1:0] sum_w;
  logic         cpa_cout;

  mac_cpa #(.W(W)) u_cpa (
    .op_s  (s_ch[ROWS]),
    .op_c  (c_ch[ROWS]),
    .total (sum_w),
    .cout  (cpa_cout)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_i_n)
    v_ch[ROWS] |-> !cpa_cout); // R6

  if (PIPE) begin : g_out_reg
    logic         vo_q;
    logic [W-1:0] res_q, res_d;

    always_comb begin
      res_d = res_q;
      if (v_ch[ROWS]) res_d = sum_w;
    end

    always_ff @(posedge clk) begin
      res_q <= res_d;
    end

    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) vo_q <= 1'b0;
      else          vo_q <= v_ch[ROWS];
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
      !v_ch[ROWS] |=> $stable(res_q)); // R5

    assign valid_out = vo_q;
    assign result    = res_q;
  end else begin : g_out_wire
    assign valid_out = v_ch[ROWS];
    assign result    = sum_w;
  end

  initial begin
    if (K < 2) $error("mac_array: K must be at least 2");
    if (LAT != (PIPE ? K : 0)) $error("mac_array: latency mismatch");
  end

endmodule

// File: tb/mac_array_test.sv
module mac_array_test;

  logic clk;
  logic rst_n;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic        v8, v4, vc;
  logic [7:0]  a8, x8, y8;
  logic [3:0]  a4, x4, y4, ac, xc, yc;
  logic        v8o, v4o, vco;
  logic [15:0] r8o;
  logic [7:0]  r4o, rco;

  mac_array #(.K(8), .PIPE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .valid_in(v8), .a_in(a8), .x_in(x8), .y_in(y8),
    .valid_out(v8o), .result(r8o)
  );

  mac_array #(.K(4), .PIPE(1'b1)) uut_k4 (
    .clk(clk), .rst_n(rst_n), .valid_in(v4), .a_in(a4), .x_in(x4), .y_in(y4),
    .valid_out(v4o), .result(r4o)
  );

  mac_array #(.K(4), .PIPE(1'b0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .valid_in(vc), .a_in(ac), .x_in(xc), .y_in(yc),
    .valid_out(vco), .result(rco)
  );

  int n_run;
  int n_fail;
  logic [16:0] q8[$];
  logic [8:0]  q4[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // One cycle: compare results due now, then drive the next operand sets.
  task automatic step(input string req,
                      input logic vi8, input logic [7:0] ai8, input logic [7:0] xi8, input logic [7:0] yi8,
                      input logic vi4, input logic [3:0] ai4, input logic [3:0] xi4, input logic [3:0] yi4);
    logic [16:0] e8;
    logic [8:0]  e4;
    @(negedge clk);
    if (q8.size() == 8) begin
      e8 = q8.pop_front();
      check({req, " k8 valid"}, 32'(v8o), 32'(e8[16]));
      if (e8[16]) check({req, " k8 result"}, 32'(r8o), 32'(e8[15:0]));
    end
    if (q4.size() == 4) begin
      e4 = q4.pop_front();
      check({req, " k4 valid"}, 32'(v4o), 32'(e4[8]));
      if (e4[8]) check({req, " k4 result"}, 32'(r4o), 32'(e4[7:0]));
    end
    v8 = vi8; a8 = ai8; x8 = xi8; y8 = yi8;
    v4 = vi4; a4 = ai4; x4 = xi4; y4 = yi4;
    q8.push_back({vi8, vi8 ? 16'(ai8 * xi8 + yi8) : 16'h0});
    q4.push_back({vi4, vi4 ? 8'(ai4 * xi4 + yi4) : 8'h0});
  endtask

  task automatic flush(input string req);
    for (int i = 0; i < 9; i++) step(req, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0, 4'h0, 4'h0, 4'h0);
  endtask

  // R7: valid held high during reset must not reach the outputs.
  task automatic t_reset();
    rst_n = 1'b0;
    v8 = 1'b1; v4 = 1'b1; a8 = 8'hff; x8 = 8'hff; y8 = 8'hff; a4 = 4'hf; x4 = 4'hf; y4 = 4'hf;
    repeat (6) @(negedge clk);
    check("R7 valid_out k8 in reset", 32'(v8o), 32'd0);
    check("R7 valid_out k4 in reset", 32'(v4o), 32'd0);
    rst_n = 1'b1;
    v8 = 1'b0; v4 = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R7 valid_out k8 after release", 32'(v8o), 32'd0);
      check("R7 valid_out k4 after release", 32'(v4o), 32'd0);
    end
  endtask

  // R3, R6, R2: zero operands, addend only, no addend, all ones.
  task automatic t_corners();
    step("R3", 1'b1, 8'h00, 8'h00, 8'h00, 1'b1, 4'h0, 4'h0, 4'h0);
    step("R3", 1'b1, 8'h00, 8'h5a, 8'hc3, 1'b1, 4'h0, 4'h9, 4'hb);
    step("R3", 1'b1, 8'h77, 8'h00, 8'hff, 1'b1, 4'h7, 4'h0, 4'hf);
    step("R3", 1'b1, 8'hd5, 8'hb3, 8'h00, 1'b1, 4'hd, 4'hb, 4'h0);
    step("R6", 1'b1, 8'hff, 8'hff, 8'hff, 1'b1, 4'hf, 4'hf, 4'hf);
    step("R6", 1'b1, 8'hff, 8'hff, 8'h00, 1'b1, 4'hf, 4'hf, 4'h0);
    step("R2", 1'b1, 8'haa, 8'h55, 8'h81, 1'b1, 4'ha, 4'h5, 4'h9);
    step("R2", 1'b1, 8'h01, 8'h80, 8'h7f, 1'b1, 4'h1, 4'h8, 4'h7);
    flush("R3 R6 R2");
  endtask

  // R1, R4: back-to-back random operand sets.
  task automatic t_burst();
    for (int i = 0; i < 80; i++)
      step("R1 R4", 1'b1, 8'($urandom), 8'($urandom), 8'($urandom),
           1'b1, 4'($urandom), 4'($urandom), 4'($urandom));
    flush("R1 R4");
  endtask

  // R4: a lone operand set must surface exactly K edges later.
  task automatic t_single();
    step("R4", 1'b1, 8'h3c, 8'he1, 8'h42, 1'b1, 4'h3, 4'he, 4'h4);
    flush("R4");
  endtask

  // R5: gapped stream keeps its spacing.
  task automatic t_bubbles();
    for (int i = 0; i < 80; i++)
      step("R5", 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
           1'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
    flush("R5");
  endtask

  // R8: combinational variant, every operand combination.
  task automatic t_comb();
    for (int a = 0; a < 16; a++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++) begin
          vc = 1'(a + x + y); ac = 4'(a); xc = 4'(x); yc = 4'(y);
          #1;
          check("R8 result", 32'(rco), 32'(a * x + y));
          if ((a + x + y) % 97 == 0) check("R8 valid", 32'(vco), 32'(vc));
        end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    vc = 1'b0; ac = '0; xc = '0; yc = '0;
    t_reset();
    t_corners();
    t_burst();
    t_single();
    t_bubbles();
    t_comb();
    summary();
    $finish;
  end

endmodule